// File: doc/BRIEF.md
# Beam-Synchronised Register Sequencer

This block walks a list of two-word commands held in shared memory and replays it once per video frame, timed against the scan beam. Each command is fetched over a request/grant port, one 16-bit word per granted cycle. A command may write a 16-bit value into a chip register, hold execution until the beam reaches a chosen screen position, or conditionally step over the following command depending on where the beam is.

A single-cycle frame pulse sends the sequencer back to the list base address. Register writes leave the block through a write strobe with an index and data. Writes are not undone between frames, so whatever the list last wrote stays in effect at the top of the next frame. While the sequencer holds on a beam position it raises no fetch requests, which leaves those memory cycles free for other bus users.

Beam positions are compared as a 15-bit key: the vertical line (8 bits) above the horizontal position (7 bits, in two-pixel units). A per-bit mask selects which key bits take part. The test is an unsigned greater-or-equal on the masked values.

Top module: `dlist_copro`

## Requirements
- R1: After reset, and before the first frame pulse, the block raises neither `mem_req` nor `reg_we`.
- R2: In the cycle after a frame pulse, `mem_req` is high with `mem_addr` equal to `list_base`. Words are fetched from consecutive addresses, one per cycle in which `mem_req` and `mem_gnt` are both high, with `mem_rdata` valid in that same cycle. An ungranted request keeps `mem_req` and `mem_addr` unchanged.
- R3: A command whose first word has bit 0 clear is a register write. It writes the second word to the register index given by first-word bits [8:1]. If any of first-word bits [15:9] is set, the write is dropped and no strobe is produced. Two write strobes are never on adjacent cycles.
- R4: A command whose first word has bit 0 set and whose second word has bit 0 clear is a hold. The target key is first-word bits [15:1] and the mask is second-word bits [15:1]. Execution resumes once (key & mask) >= (target & mask), where key = {`beam_line`, `beam_hpos`}.
- R5: While a hold is unsatisfied, `mem_req` stays low.
- R6: A command whose first word has bit 0 set and whose second word has bit 0 set is a conditional step. It never stalls. When the masked comparison of R4 holds, the following command is not executed; otherwise it is.
- R7: The command pair 0xFFFF, 0xFFFE ends the list. The block then stays idle (no requests, no writes) until the next frame pulse, whatever the beam position, including the maximum key.
- R8: A frame pulse restarts the list from the current `list_base` from any state, including an unsatisfied hold. The list runs again on every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the top of each frame |
| list_base | input | ADDR_W | Word address of the first command |
| beam_line | input | 8 | Vertical beam counter |
| beam_hpos | input | 7 | Horizontal beam counter in two-pixel units |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | ADDR_W | Word address being fetched |
| mem_gnt | input | 1 | Fetch granted this cycle |
| mem_rdata | input | 16 | Fetched word, valid with the grant |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | REG_IDX_W | Register index written |
| reg_wdata | output | 16 | Register write data |

## Verification
The assertions assume three things about the inputs. `frame_start` is a single-cycle pulse. `mem_rdata` is valid in the same cycle as the grant that accepts it. The beam counters only matter in the cycles when a hold or step compares against them. The bench keeps within these assumptions: it pulses the frame for exactly one cycle, serves fetch data combinationally from its own word array indexed by `mem_addr`, and holds the beam constant for a whole run, changing it only on a falling edge when it wants to release a hold. Grants are either always given or withheld for a stretch and then restored, so the request-holding rule is exercised under both conditions.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned LINE_W = 8;
    localparam int unsigned HPOS_W = 7;
    localparam int unsigned KEY_W  = LINE_W + HPOS_W;

    localparam logic [WORD_W-1:0] END_HI = 16'hFFFF;
    localparam logic [WORD_W-1:0] END_LO = 16'hFFFE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_EXEC,
        ST_STALL,
        ST_HALT
    } dlc_state_e;

    typedef enum logic [1:0] {
        OP_MOVE,
        OP_WAIT,
        OP_SKIP,
        OP_HALT
    } dlc_op_e;

    typedef struct packed {
        dlc_op_e          op;
        logic             in_range;
        logic [KEY_W-1:0] target;
        logic [KEY_W-1:0] mask;
    } dlc_instr_t;

    function automatic logic [KEY_W-1:0] beam_key(input logic [LINE_W-1:0] line,
                                                  input logic [HPOS_W-1:0] hpos);
        return {line, hpos};
    endfunction

endpackage

// File: rtl/dlc_decode.sv
module dlc_decode
    import dlc_pkg::*;
#(
    parameter int unsigned REG_IDX_W = 8
) (
    input  logic [WORD_W-1:0]    w_hi,
    input  logic [WORD_W-1:0]    w_lo,
    output dlc_instr_t           instr,
    output logic [REG_IDX_W-1:0] reg_idx
);

    logic in_range;

    generate
        if (REG_IDX_W >= WORD_W - 1) begin : g_full_range
            assign in_range = 1'b1;
        end else begin : g_part_range
            assign in_range = (w_hi[WORD_W-1:REG_IDX_W+1] == '0);
        end
    endgenerate

    assign reg_idx = w_hi[REG_IDX_W:1];

    always_comb begin
        instr.target   = w_hi[WORD_W-1:1];
        instr.mask     = w_lo[WORD_W-1:1];
        instr.in_range = in_range;
        if (!w_hi[0]) begin
            instr.op = OP_MOVE;
        end else if (w_hi == END_HI && w_lo == END_LO) begin
            instr.op = OP_HALT;
        end else if (w_lo[0]) begin
            instr.op = OP_SKIP;
        end else begin
            instr.op = OP_WAIT;
        end
    end

endmodule

// File: rtl/dlc_beam_cmp.sv
module dlc_beam_cmp
    import dlc_pkg::*;
(
    input  logic [KEY_W-1:0] beam,
    input  logic [KEY_W-1:0] target,
    input  logic [KEY_W-1:0] mask,
    output logic             reached
);

    logic [KEY_W-1:0] beam_m;
    logic [KEY_W-1:0] target_m;

    assign beam_m   = beam & mask;
    assign target_m = target & mask;
    assign reached  = (beam_m >= target_m);

endmodule

// File: rtl/dlist_copro.sv
module dlist_copro
    import dlc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned REG_IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic [ADDR_W-1:0]    list_base,
    input  logic [LINE_W-1:0]    beam_line,
    input  logic [HPOS_W-1:0]    beam_hpos,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_gnt,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 reg_we,
    output logic [REG_IDX_W-1:0] reg_addr,
    output logic [WORD_W-1:0]    reg_wdata
);

    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

    dlc_state_e           st;
    logic [ADDR_W-1:0]    pc;
    logic [WORD_W-1:0]    w_hi;
    logic [WORD_W-1:0]    w_lo;
    dlc_instr_t           instr;
    logic [REG_IDX_W-1:0] reg_idx;
    logic                 reached;

    dlc_decode #(.REG_IDX_W(REG_IDX_W)) u_decode (
        .w_hi    (w_hi),
        .w_lo    (w_lo),
        .instr   (instr),
        .reg_idx (reg_idx)
    );

    dlc_beam_cmp u_cmp (
        .beam    (beam_key(beam_line, beam_hpos)),
        .target  (instr.target),
        .mask    (instr.mask),
        .reached (reached)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            pc   <= '0;
            w_hi <= '0;
            w_lo <= '0;
        end else if (frame_start) begin
            st <= ST_FETCH_HI;
            pc <= list_base;
        end else begin
            unique case (st)
                ST_FETCH_HI: if (mem_gnt) begin
                    w_hi <= mem_rdata;
                    pc   <= pc + STEP_ONE;
                    st   <= ST_FETCH_LO;
                end
                ST_FETCH_LO: if (mem_gnt) begin
                    w_lo <= mem_rdata;
                    pc   <= pc + STEP_ONE;
                    st   <= ST_EXEC;
                end
                ST_EXEC: begin
                    unique case (instr.op)
                        OP_MOVE: st <= ST_FETCH_HI;
                        OP_WAIT: st <= ST_STALL;
                        OP_SKIP: begin
                            if (reached) pc <= pc + STEP_TWO;
                            st <= ST_FETCH_HI;
                        end
                        OP_HALT: st <= ST_HALT;
                        default: st <= ST_HALT;
                    endcase
                end
                ST_STALL: if (reached) st <= ST_FETCH_HI;
                ST_IDLE, ST_HALT: st <= st;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (st == ST_FETCH_HI) || (st == ST_FETCH_LO);
    assign mem_addr  = pc;
    assign reg_we    = (st == ST_EXEC) && (instr.op == OP_MOVE) && instr.in_range;
    assign reg_addr  = reg_idx;
    assign reg_wdata = w_lo;

    // R2: an ungranted request is held with a stable address
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt && !frame_start) |=> (mem_req && $stable(mem_addr)));

    // R8: a frame pulse restarts fetching at the base address
    p_frame_restart_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (mem_req && mem_addr == $past(list_base)));

    // R3: every write needs two fresh fetches, so strobes never touch
    p_write_spaced_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R5: an unsatisfied hold leaves the bus alone
    p_stall_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STALL && !reached && !frame_start) |=> !mem_req);

    // R6: a step resumes fetching at once, past the next command when reached
    p_skip_target_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && instr.op == OP_SKIP && !frame_start) |=>
        (mem_req && mem_addr == $past(pc) + ($past(reached) ? STEP_TWO : '0)));

    // R7: the end marker keeps the block silent until the next frame
    p_halt_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HALT && !frame_start) |=> (!mem_req && !reg_we));

endmodule

// File: tb/test_dlist_copro.sv
module test_dlist_copro;

    localparam time CLK_PERIOD = 10ns;
    localparam int  AW         = 10;
    localparam int  RW         = 8;
    localparam int  WD_CYCLES  = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          frame_start;
    logic [AW-1:0] list_base;
    logic [7:0]    beam_line;
    logic [6:0]    beam_hpos;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_gnt;
    logic [15:0]   mem_rdata;
    logic          reg_we;
    logic [RW-1:0] reg_addr;
    logic [15:0]   reg_wdata;

    logic [15:0]   mem [0:63];
    int            n_checks = 0;
    int            n_fail   = 0;
    int            wr_n     = 0;
    logic [RW-1:0] wr_idx [0:63];
    logic [15:0]   wr_dat [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[5:0]];

    dlist_copro #(.ADDR_W(AW), .REG_IDX_W(RW)) i_dlist_copro (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .list_base   (list_base),
        .beam_line   (beam_line),
        .beam_hpos   (beam_hpos),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata)
    );

    always @(negedge clk) begin
        if (!rst && reg_we) begin
            wr_idx[wr_n[5:0]] = reg_addr;
            wr_dat[wr_n[5:0]] = reg_wdata;
            wr_n = wr_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic reach(input logic [7:0] ln, input logic [6:0] hp,
                                   input logic [15:0] t, input logic [15:0] m);
        logic [14:0] key;
        key = {ln, hp};
        return (key & m[15:1]) >= (t[15:1] & m[15:1]);
    endfunction

    task automatic put(input int a, input logic [15:0] hi, input logic [15:0] lo);
        mem[a]   = hi;
        mem[a+1] = lo;
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_all();
        int base;
        logic [15:0] tgts  [4] = '{16'h9001, 16'h0001, 16'h90FF, 16'h4021};
        logic [15:0] masks [5] = '{16'hFFFE, 16'hFF00, 16'h00FE, 16'hF0F0, 16'h0000};
        logic [7:0]  lines [6] = '{8'h00, 8'h40, 8'h8F, 8'h90, 8'h91, 8'hC0};
        logic [6:0]  hps   [4] = '{7'h00, 7'h10, 7'h3F, 7'h7F};

        rst = 1'b1; frame_start = 1'b0; mem_gnt = 1'b1; list_base = '0;
        beam_line = '0; beam_hpos = '0;
        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
        idle(3);
        rst = 1'b0;
        // R1: silent after reset
        for (int i = 0; i < 5; i++) begin
            idle(1);
            check("R1 req", mem_req, 0);
            check("R1 we", reg_we, 0);
        end

        // R2: fetch start and stalled grant
        put(0, 16'h0180, 16'h0ABC);
        put(2, 16'hFFFF, 16'hFFFE);
        mem_gnt = 1'b0; list_base = 0; base = wr_n;
        pulse_frame();
        for (int i = 0; i < 4; i++) begin
            check("R2 req held", mem_req, 1);
            check("R2 addr held", mem_addr, 0);
            idle(1);
        end
        mem_gnt = 1'b1;
        idle(1);
        check("R2 second word addr", mem_addr, 1);
        idle(8);
        check("R3 single write", wr_n - base, 1);
        check("R3 index", wr_idx[base[5:0]], 8'hC0);
        check("R3 data", wr_dat[base[5:0]], 16'h0ABC);

        // R3: out-of-range offset dropped, edge indices kept
        put(0, 16'h0380, 16'h1111);
        put(2, 16'h01FE, 16'h2222);
        put(4, 16'h0000, 16'h3333);
        put(6, 16'hFFFF, 16'hFFFE);
        base = wr_n;
        pulse_frame(); idle(16);
        check("R3 count", wr_n - base, 2);
        check("R3 top index", wr_idx[base[5:0]], 8'hFF);
        check("R3 top data", wr_dat[base[5:0]], 16'h2222);
        check("R3 zero index", wr_idx[6'(base+1)], 8'h00);

        // R4, R5: hold sweep
        foreach (tgts[ti]) foreach (masks[mi]) foreach (lines[li]) foreach (hps[hi]) begin
            logic exp;
            put(0, tgts[ti], masks[mi]);
            put(2, 16'h0180, 16'h0F00 ^ 16'(li));
            put(4, 16'hFFFF, 16'hFFFE);
            beam_line = lines[li]; beam_hpos = hps[hi];
            exp = reach(lines[li], hps[hi], tgts[ti], masks[mi]);
            base = wr_n;
            pulse_frame(); idle(9);
            check("R4 hold release", wr_n - base, exp ? 1 : 0);
            if (!exp) check("R5 no fetch while held", mem_req, 0);
        end

        // R4: held hold released by beam advance
        put(0, 16'h9001, 16'hFFFE);
        put(2, 16'h0180, 16'h0777);
        put(4, 16'hFFFF, 16'hFFFE);
        beam_line = 8'h8F; beam_hpos = 7'h7F; base = wr_n;
        pulse_frame(); idle(10);
        check("R4 not yet", wr_n - base, 0);
        check("R5 idle bus", mem_req, 0);
        beam_line = 8'h90; beam_hpos = 7'h00;
        idle(8);
        check("R4 released", wr_n - base, 1);
        check("R4 data", wr_dat[base[5:0]], 16'h0777);

        // R6: step sweep
        foreach (tgts[ti]) foreach (masks[mi]) foreach (lines[li]) begin
            logic exp;
            put(0, tgts[ti], masks[mi] | 16'h0001);
            put(2, 16'h0180, 16'hAAAA);
            put(4, 16'h0182, 16'hBBBB);
            put(6, 16'hFFFF, 16'hFFFE);
            beam_line = lines[li]; beam_hpos = 7'h20;
            exp = reach(lines[li], 7'h20, tgts[ti], masks[mi] | 16'h0001);
            base = wr_n;
            pulse_frame(); idle(16);
            check("R6 write count", wr_n - base, exp ? 1 : 2);
            check("R6 first data", wr_dat[base[5:0]], exp ? 16'hBBBB : 16'hAAAA);
        end

        // R7: end marker holds even at maximum beam key
        put(0, 16'hFFFF, 16'hFFFE);
        put(2, 16'h0180, 16'h5555);
        beam_line = 8'hFF; beam_hpos = 7'h7F; base = wr_n;
        pulse_frame(); idle(3);
        for (int i = 0; i < 10; i++) begin
            check("R7 no req", mem_req, 0);
            idle(1);
        end
        check("R7 no write", wr_n - base, 0);

        // R8: restart out of an unsatisfied hold onto a new base
        put(0, 16'hC001, 16'hFFFE);
        put(2, 16'h0180, 16'h6666);
        put(4, 16'hFFFF, 16'hFFFE);
        put(32, 16'h0184, 16'h7777);
        put(34, 16'hFFFF, 16'hFFFE);
        beam_line = 8'h10; beam_hpos = 7'h00; list_base = 0; base = wr_n;
        pulse_frame(); idle(6);
        check("R8 held", wr_n - base, 0);
        list_base = 32;
        pulse_frame();
        check("R8 new base", mem_addr, 32);
        idle(8);
        check("R8 write after restart", wr_n - base, 1);
        check("R8 restart data", wr_dat[base[5:0]], 16'h7777);
        base = wr_n;
        pulse_frame(); idle(8);
        pulse_frame(); idle(8);
        check("R8 every frame", wr_n - base, 2);
        check("R8 index", wr_idx[base[5:0]], 8'hC2);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WD_CYCLES) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule